// File: doc/BRIEF.md
# Phase-Shifted Clock Pair Generator

This block divides a fast parent clock into a module clock and derives two more clocks from it: an output clock and a sample clock. Each derived clock has the same period and duty cycle as the module clock and is placed against it in whole parent-clock steps. For a divide ratio D, one step is worth 360/D degrees.

A single counter running on the parent clock drives all three outputs, and every output is a flip-flop. The divide ratio and the two delay codes are taken at the start of each module-clock period. Each delay code is a 2-bit field in a shared 32-bit control word. A code of zero does not mean zero shift: it selects the inverted (180-degree) clock. A nonzero code k moves the clock edges k parent cycles later. If k is not below the ratio, the code cannot be met and the clock falls back to the inverted setting.

Top module: `phase_clk_gen`

## Requirements
- R1: While `rst_n` is low, `ref_clk`, `out_clk` and `smp_clk` are all low.
- R2: Parent edge n after reset release (n = 0, 1, ...) puts the period counter at n mod D. `ref_clk` is high when that count is below floor(D/2) and low otherwise, so it rises at count 0 and repeats every D parent cycles.
- R3: A delay code of 0 makes the derived clock the logical inverse of `ref_clk`.
- R4: A delay code k in 1..3 with k < D makes the derived clock high exactly when ((count - k) mod D) < floor(D/2). This is `ref_clk` delayed by k parent cycles.
- R5: A nonzero delay code k with k >= D makes the derived clock the inverse of `ref_clk`.
- R6: A `div_ratio` value of 0 or 1 is treated as a ratio of 2.
- R7: `div_ratio` and both delay codes are captured only on the edge where the count returns to 0, which includes the first edge after reset. Changes made inside a period have no effect until the next period starts.
- R8: `out_clk` takes its delay code from `phase_ctl[9:8]` and `smp_clk` takes its code from `phase_ctl[21:20]`. The two codes act independently.
- R9: Bits of `phase_ctl` outside [9:8] and [21:20] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_par | input | 1 | Fast parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | DIV_W | Parent-to-module divide ratio |
| phase_ctl | input | CTL_W | Shared control word holding both delay codes |
| ref_clk | output | 1 | Divided module clock, the phase reference |
| out_clk | output | 1 | Output clock, shifted by the code in [9:8] |
| smp_clk | output | 1 | Sample clock, shifted by the code in [21:20] |

## Verification
The bench sweeps every divide ratio from 0 to 7 against all sixteen pairs of output and sample codes. It compares all three clocks on every parent cycle with an arithmetic model of the period count. Ratios 0 and 1 separate the clamp-to-2 rule from plain division. Ratios 2 and 3 put codes on both sides of the k < D limit, which separates a real shift from the inverted fallback. A code of 0 separates inversion from zero shift. Alternating junk in the unused control bits shows that they have no effect. Because the settings change in the middle of a period, the cycles just after each change show whether the update waits for the period boundary. A reset pulse at the end of the sweep checks that all clocks are held low.

// File: rtl/phase_clk_gen.sv
module phase_clk_gen #(
  parameter int DIV_W   = 8,
  parameter int CODE_W  = 2,
  parameter int CTL_W   = 32,
  parameter int OUT_LSB = 8,
  parameter int SMP_LSB = 20
) (
  input  logic             clk_par,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic [CTL_W-1:0] phase_ctl,
  output logic             ref_clk,
  output logic             out_clk,
  output logic             smp_clk
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);
  localparam int               PAD_W   = DIV_W - CODE_W;

  logic [DIV_W-1:0]  cnt_q, div_q;
  logic [CODE_W-1:0] ko_q, ks_q;
  logic              run_q;

  wire [DIV_W-1:0]  div_in = (div_ratio < MIN_DIV) ? MIN_DIV : div_ratio;
  wire [CODE_W-1:0] ko_in  = phase_ctl[OUT_LSB +: CODE_W];
  wire [CODE_W-1:0] ks_in  = phase_ctl[SMP_LSB +: CODE_W];

  wire              wrap  = !run_q || (cnt_q == div_q - 1'b1);
  wire [DIV_W-1:0]  cnt_n = wrap ? '0 : cnt_q + 1'b1;
  wire [DIV_W-1:0]  div_n = wrap ? div_in : div_q;
  wire [CODE_W-1:0] ko_n  = wrap ? ko_in : ko_q;
  wire [CODE_W-1:0] ks_n  = wrap ? ks_in : ks_q;
  wire [DIV_W-1:0]  half_n = div_n >> 1;

  function automatic logic shifted(input logic [DIV_W-1:0] c,
                                   input logic [DIV_W-1:0] d,
                                   input logic [CODE_W-1:0] k);
    logic [DIV_W:0] p;
    logic [DIV_W-1:0] kx;
    kx = {{PAD_W{1'b0}}, k};
    if (k == '0 || kx >= d) begin
      return !(c < (d >> 1));
    end
    p = {1'b0, c} + {1'b0, d} - {1'b0, kx};
    if (p >= {1'b0, d}) p = p - {1'b0, d};
    return p < {1'b0, d >> 1};
  endfunction

  always_ff @(posedge clk_par or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      div_q   <= MIN_DIV;
      ko_q    <= '0;
      ks_q    <= '0;
      ref_clk <= 1'b0;
      out_clk <= 1'b0;
      smp_clk <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      cnt_q   <= cnt_n;
      div_q   <= div_n;
      ko_q    <= ko_n;
      ks_q    <= ks_n;
      ref_clk <= cnt_n < half_n;
      out_clk <= shifted(cnt_n, div_n, ko_n);
      smp_clk <= shifted(cnt_n, div_n, ks_n);
    end
  end

  always @(negedge clk_par) begin
    if (!rst_n) begin
      p_low_in_reset_r1: assert (!ref_clk && !out_clk && !smp_clk)
        else $error("clocks not low during reset");
    end
  end

  p_rise_at_zero_r2: assert property (@(posedge clk_par) disable iff (!rst_n)
    $rose(ref_clk) |-> cnt_q == '0);

  p_code0_inverts_r3: assert property (@(posedge clk_par) disable iff (!rst_n)
    (run_q && ko_q == '0) |-> out_clk != ref_clk);

  p_delay1_r4: assert property (@(posedge clk_par) disable iff (!rst_n)
    (run_q && ko_q == 2'd1 && div_q > DIV_W'(1) && cnt_q >= DIV_W'(1))
      |-> out_clk == $past(ref_clk, 1));

  p_delay2_r4: assert property (@(posedge clk_par) disable iff (!rst_n)
    (run_q && ko_q == 2'd2 && div_q > DIV_W'(2) && cnt_q >= DIV_W'(2))
      |-> out_clk == $past(ref_clk, 2));

  p_delay3_r4: assert property (@(posedge clk_par) disable iff (!rst_n)
    (run_q && ks_q == 2'd3 && div_q > DIV_W'(3) && cnt_q >= DIV_W'(3))
      |-> smp_clk == $past(ref_clk, 3));

  p_fallback_r5: assert property (@(posedge clk_par) disable iff (!rst_n)
    (run_q && ks_q != '0 && {{PAD_W{1'b0}}, ks_q} >= div_q) |-> smp_clk != ref_clk);

  p_min_ratio_r6: assert property (@(posedge clk_par) disable iff (!rst_n)
    run_q |-> div_q >= MIN_DIV);

  p_hold_mid_period_r7: assert property (@(posedge clk_par) disable iff (!rst_n)
    (run_q && cnt_q != div_q - 1'b1) |=> ($stable(div_q) && $stable(ko_q) && $stable(ks_q)));

endmodule

// File: tb/phase_clk_gen_tb.sv
module phase_clk_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div_ratio = 8'd4;
  logic [31:0] phase_ctl = '0;
  logic ref_clk, out_clk, smp_clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phase_clk_gen u_dut (
    .clk_par(clk), .rst_n(rst_n), .div_ratio(div_ratio), .phase_ctl(phase_ctl),
    .ref_clk(ref_clk), .out_clk(out_clk), .smp_clk(smp_clk)
  );

  int m_cnt, m_d, m_ko, m_ks;
  bit m_run, m_clamped;

  function automatic int clampd(int d);
    return (d < 2) ? 2 : d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0;
      m_cnt <= 0;
    end else begin
      m_run <= 1;
      if (!m_run || m_cnt == m_d - 1) begin
        m_cnt     <= 0;
        m_d       <= clampd(int'(div_ratio));
        m_clamped <= div_ratio < 2;
        m_ko      <= int'(phase_ctl[9:8]);
        m_ks      <= int'(phase_ctl[21:20]);
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  function automatic bit exp_shift(int c, int d, int k);
    if (k == 0 || k >= d) return !(c < d / 2);
    return ((c - k + d) % d) < d / 2;
  endfunction

  function automatic string ch_tag(int k, int d);
    if (k == 0) return "R3";
    if (k < d) return "R4";
    return "R5";
  endfunction

  task automatic cmp(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cmp("R1 ref", ref_clk, 1'b0);
      cmp("R1 out", out_clk, 1'b0);
      cmp("R1 smp", smp_clk, 1'b0);
    end else if (m_run) begin
      string extra;
      extra = "";
      if (clampd(int'(div_ratio)) != m_d || int'(phase_ctl[9:8]) != m_ko
          || int'(phase_ctl[21:20]) != m_ks) extra = " R7";
      if ((phase_ctl & ~32'h0030_0300) != 0) extra = {extra, " R9"};
      cmp(m_clamped ? "R6 ref" : "R2 ref", ref_clk, m_cnt < m_d / 2);
      cmp({ch_tag(m_ko, m_d), " out", extra}, out_clk, exp_shift(m_cnt, m_d, m_ko));
      cmp({"R8 ", ch_tag(m_ks, m_d), " smp", extra}, smp_clk, exp_shift(m_cnt, m_d, m_ks));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int d = 0; d < 8; d++) begin
      for (int co = 0; co < 4; co++) begin
        for (int cs = 0; cs < 4; cs++) begin
          logic [31:0] junk;
          junk = ((d + co + cs) % 2 == 1) ? 32'hA5C3_F0F0 : 32'h0;
          @(negedge clk); #2;
          div_ratio = 8'(d);
          phase_ctl = (junk & ~32'h0030_0300) | (32'(cs) << 20) | (32'(co) << 8);
          repeat (21) @(negedge clk);
        end
      end
    end
    @(negedge clk); #2;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (20) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule